// File: doc/BRIEF.md
# Subroutine Call and Return Bus Sequencer

This block is the control sequencer of an 8-bit processor with a 16-bit address space, limited to the unconditional subroutine call and return instructions. It owns the program counter and the stack pointer. It drives a simple synchronous memory bus through a fixed series of machine cycles: an opcode fetch, memory reads and memory writes. Each machine cycle is split into numbered T-states. A call reads a two-byte target, pushes the return address onto a descending stack and jumps. A return pops a saved address into the program counter. Any other opcode is a one-byte no-op that costs only its fetch.

The sequencer has seven named states. FETCH reads the opcode. TGT_LO and TGT_HI read the target bytes. PUSH_HI and PUSH_LO write the return address. POP_LO and POP_HI read the saved address. The transitions are taken at the last T-state of a machine cycle:
- FETCH goes to TGT_LO on opcode 0xCD, to POP_LO on opcode 0xC9, and back to FETCH on any other opcode.
- TGT_LO goes to TGT_HI, then PUSH_HI, then PUSH_LO, then FETCH.
- POP_LO goes to POP_HI, then FETCH.

Top module: `call_ret_seq`

## Requirements
- R1: While reset is asserted, pc and sp read 0, the sequencer is in the FETCH state at T-state 1, and mcycle shows fetch. The first cycle after release is fetch T1 with mem_addr = 0.
- R2: An opcode fetch drives mem_addr = pc and mcycle = 2'b01. It asserts mem_rd in T-states 2 and 3 only and samples the opcode from mem_rdata at the end of T3. pc advances by one when the fetch ends.
- R3: A call (opcode 0xCD) runs a 6-T-state fetch followed by read, read, write and write cycles of 3 T-states each, for 18 T-states in total.
- R4: A call reads the low target byte from the address after the opcode and the high target byte from the address after that.
- R5: A call writes the high byte of the return address (the call's own address + 3) to sp-1 and then the low byte to sp-2. The write cycles show mcycle = 2'b11, and sp ends 2 lower.
- R6: pc holds the return address throughout both stack writes and is loaded with the target only when the second write ends.
- R7: A return (opcode 0xC9) runs a 4-T-state fetch followed by two 3-T-state read cycles (mcycle = 2'b10), 10 T-states in total. It reads the low byte at sp and the high byte at sp+1, loads pc from them, and ends with sp 2 higher.
- R8: Any other opcode is a 4-T-state fetch with no further bus cycle. pc advances by one and sp is left unchanged.
- R9: mem_rd and mem_wr are never active together, and neither is active in T1 or after T3 of any cycle.
- R10: Stack pointer and stack address arithmetic wrap modulo 2^16 (a push from sp = 0 writes 0xFFFF and then 0xFFFE).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_rdata | input | 8 | Read data, sampled at the end of T3 of a fetch or read cycle |
| mem_addr | output | 16 | Bus address, held for the whole machine cycle |
| mem_wdata | output | 8 | Write data, valid while mem_wr is high |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe; memory stores on the clock edge while it is high |
| mcycle | output | 2 | Machine cycle kind: 01 fetch, 10 read, 11 write |
| tstate | output | 3 | Current T-state number, starting at 1 |
| pc | output | 16 | Program counter |
| sp | output | 16 | Stack pointer |

## Verification
The assertions check every cycle that the two strobes are mutually exclusive and that memory cycles stay within three T-states. They also check that the fetch address and sp hold steady during a fetch, that pc holds through the return-address push, and that a fetch cannot end before T4. Only the bench's scenarios can show the end-to-end results: the exact machine-cycle order and T-state totals of each instruction, the byte order on the stack, the push and pop addresses, the wrap of sp through zero, and the values pc takes after nested calls and returns. The bench gets these from an independent cycle-level model of the instruction stream.

// File: rtl/crs_pkg.sv
package crs_pkg;
    typedef enum logic [2:0] {
        ST_FETCH   = 3'd0,
        ST_TGT_LO  = 3'd1,
        ST_TGT_HI  = 3'd2,
        ST_PUSH_HI = 3'd3,
        ST_PUSH_LO = 3'd4,
        ST_POP_LO  = 3'd5,
        ST_POP_HI  = 3'd6
    } seq_state_t;

    typedef enum logic [1:0] {
        MC_NONE  = 2'b00,
        MC_FETCH = 2'b01,
        MC_READ  = 2'b10,
        MC_WRITE = 2'b11
    } mcyc_t;

    localparam logic [7:0] OP_CALL = 8'hCD;
    localparam logic [7:0] OP_RET  = 8'hC9;
endpackage

// File: rtl/crs_timing.sv
module crs_timing
    import crs_pkg::*;
#(
    parameter int DW        = 8,
    parameter int TW        = 3,
    parameter int FETCH_SHT = 4,
    parameter int FETCH_LNG = 6,
    parameter int MEM_T     = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] opcode,
    output seq_state_t    state,
    output logic [TW-1:0] tstate,
    output logic          cyc_end,
    output logic          samp
);
    localparam logic [TW-1:0] T_FIRST = TW'(1);
    localparam logic [TW-1:0] T_MEM   = TW'(MEM_T);
    localparam logic [TW-1:0] T_FSHT  = TW'(FETCH_SHT);
    localparam logic [TW-1:0] T_FLNG  = TW'(FETCH_LNG);

    seq_state_t state_nx;
    logic       is_call;

    assign is_call = (opcode == OP_CALL);
    assign samp    = (tstate == T_MEM);

    // end of the current machine cycle
    always_comb begin
        if (state == ST_FETCH)
            cyc_end = (tstate == T_FLNG) || ((tstate == T_FSHT) && !is_call);
        else
            cyc_end = (tstate == T_MEM);
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_FETCH: begin
                if (is_call)               state_nx = ST_TGT_LO;
                else if (opcode == OP_RET) state_nx = ST_POP_LO;
                else                       state_nx = ST_FETCH;
            end
            ST_TGT_LO:  state_nx = ST_TGT_HI;
            ST_TGT_HI:  state_nx = ST_PUSH_HI;
            ST_PUSH_HI: state_nx = ST_PUSH_LO;
            ST_PUSH_LO: state_nx = ST_FETCH;
            ST_POP_LO:  state_nx = ST_POP_HI;
            ST_POP_HI:  state_nx = ST_FETCH;
            default:    state_nx = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_FETCH;
            tstate <= T_FIRST;
        end else if (cyc_end) begin
            state  <= state_nx;
            tstate <= T_FIRST;
        end else begin
            tstate <= tstate + T_FIRST;
        end
    end

    // R3: read and write cycles never run past their last T-state
    a_r3_mem_cycle_len: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_FETCH) |-> (tstate >= T_FIRST && tstate <= T_MEM));

    // R8: no fetch ends before its fourth T-state
    a_r8_fetch_min_len: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH && tstate < T_FSHT) |-> !cyc_end);
endmodule

// File: rtl/crs_regs.sv
module crs_regs
    import crs_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  seq_state_t    state,
    input  logic          cyc_end,
    input  logic          samp,
    input  logic [DW-1:0] rdata,
    output logic [AW-1:0] pc,
    output logic [AW-1:0] sp,
    output logic [DW-1:0] opcode
);
    localparam logic [AW-1:0] ONE = AW'(1);

    logic [DW-1:0] tmp_lo;
    logic [DW-1:0] tmp_hi;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc     <= '0;
            sp     <= '0;
            opcode <= '0;
            tmp_lo <= '0;
            tmp_hi <= '0;
        end else begin
            unique case (state)
                ST_FETCH: begin
                    if (samp)    opcode <= rdata;
                    if (cyc_end) pc     <= pc + ONE;
                end
                ST_TGT_LO: if (samp) begin
                    tmp_lo <= rdata;
                    pc     <= pc + ONE;
                end
                ST_TGT_HI: if (samp) begin
                    tmp_hi <= rdata;
                    pc     <= pc + ONE;
                end
                ST_PUSH_HI: if (cyc_end) sp <= sp - ONE;
                ST_PUSH_LO: if (cyc_end) begin
                    sp <= sp - ONE;
                    pc <= {tmp_hi, tmp_lo};
                end
                ST_POP_LO: if (samp) begin
                    tmp_lo <= rdata;
                    sp     <= sp + ONE;
                end
                ST_POP_HI: if (samp) begin
                    pc <= {rdata, tmp_lo};
                    sp <= sp + ONE;
                end
                default: ;
            endcase
        end
    end

    // R8: the stack pointer does not move during any fetch
    a_r8_sp_stable_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH) |=> (state != ST_FETCH) || $stable(sp) || !rst_n);

    // R6: pc keeps the return address through the first push cycle
    a_r6_pc_hold_push: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PUSH_HI) |=> $stable(pc));
endmodule

// File: rtl/crs_bus.sv
module crs_bus
    import crs_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter int TW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  seq_state_t    state,
    input  logic [TW-1:0] tstate,
    input  logic [AW-1:0] pc,
    input  logic [AW-1:0] sp,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] wdata,
    output logic          rd,
    output logic          wr,
    output logic [1:0]    mcycle
);
    localparam logic [AW-1:0] ONE = AW'(1);

    logic strobe_win;
    assign strobe_win = (tstate == TW'(2)) || (tstate == TW'(3));

    always_comb begin
        addr   = pc;
        wdata  = '0;
        rd     = 1'b0;
        wr     = 1'b0;
        mcycle = MC_NONE;
        unique case (state)
            ST_FETCH: begin
                mcycle = MC_FETCH;
                rd     = strobe_win;
            end
            ST_TGT_LO, ST_TGT_HI: begin
                mcycle = MC_READ;
                rd     = strobe_win;
            end
            ST_PUSH_HI: begin
                mcycle = MC_WRITE;
                addr   = sp - ONE;
                wdata  = pc[AW-1:DW];
                wr     = strobe_win;
            end
            ST_PUSH_LO: begin
                mcycle = MC_WRITE;
                addr   = sp - ONE;
                wdata  = pc[DW-1:0];
                wr     = strobe_win;
            end
            ST_POP_LO, ST_POP_HI: begin
                mcycle = MC_READ;
                addr   = sp;
                rd     = strobe_win;
            end
            default: ;
        endcase
    end

    // R9: the two strobes are mutually exclusive
    a_r9_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd && wr));
endmodule

// File: rtl/call_ret_seq.sv
module call_ret_seq
    import crs_pkg::*;
#(
    parameter int AW        = 16,
    parameter int DW        = 8,
    parameter int TW        = 3,
    parameter int FETCH_SHT = 4,
    parameter int FETCH_LNG = 6,
    parameter int MEM_T     = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [1:0]    mcycle,
    output logic [TW-1:0] tstate,
    output logic [AW-1:0] pc,
    output logic [AW-1:0] sp
);
    seq_state_t    state;
    logic          cyc_end;
    logic          samp;
    logic [DW-1:0] opcode;

    crs_timing #(
        .DW(DW), .TW(TW), .FETCH_SHT(FETCH_SHT),
        .FETCH_LNG(FETCH_LNG), .MEM_T(MEM_T)
    ) u_timing (
        .clk(clk), .rst_n(rst_n), .opcode(opcode),
        .state(state), .tstate(tstate), .cyc_end(cyc_end), .samp(samp)
    );

    crs_regs #(.AW(AW), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .state(state), .cyc_end(cyc_end),
        .samp(samp), .rdata(mem_rdata), .pc(pc), .sp(sp), .opcode(opcode)
    );

    crs_bus #(.AW(AW), .DW(DW), .TW(TW)) u_bus (
        .clk(clk), .rst_n(rst_n), .state(state), .tstate(tstate),
        .pc(pc), .sp(sp), .addr(mem_addr), .wdata(mem_wdata),
        .rd(mem_rd), .wr(mem_wr), .mcycle(mcycle)
    );

    // R2: the fetch address holds for the whole fetch cycle
    a_r2_fetch_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mcycle == MC_FETCH && tstate != TW'(1)) |-> $stable(mem_addr));

    // R9: strobes stay low in the first T-state of every cycle
    a_r9_no_strobe_t1: assert property (@(posedge clk) disable iff (!rst_n)
        (tstate == TW'(1)) |-> !(mem_rd || mem_wr));
endmodule

// File: tb/call_ret_seq_bench.sv
module call_ret_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  mem_rdata = 8'h00;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_rd, mem_wr;
    logic [1:0]  mcycle;
    logic [2:0]  tstate;
    logic [15:0] pc, sp;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    call_ret_seq u_call_ret_seq (
        .clk(clk), .rst_n(rst_n), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mcycle(mcycle), .tstate(tstate), .pc(pc), .sp(sp)
    );

    // bench memory seen by the design, and a separate copy for the model
    logic [7:0] dmem [int];
    logic [7:0] rmem [int];

    function automatic logic [7:0] peek_d(int a);
        return dmem.exists(a) ? dmem[a] : 8'h00;
    endfunction
    function automatic logic [7:0] peek_r(int a);
        return rmem.exists(a) ? rmem[a] : 8'h00;
    endfunction

    always @(posedge clk) if (rst_n && mem_wr) dmem[int'(mem_addr)] = mem_wdata;

    typedef struct {
        int mc; int ts; int addr; bit rd; bit wr; int wd; int pc; int sp; int tag;
    } exp_t;
    exp_t q[$];
    int m_pc = 0;
    int m_sp = 0;

    task automatic chk(bit ok, int tag, string what, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // push one machine cycle of nt T-states
    task automatic add_mc(int mc, int nt, int a, bit is_wr, int wd, int p, int s, int tag);
        for (int t = 1; t <= nt; t++) begin
            exp_t e;
            e.mc = mc; e.ts = t; e.addr = a & 16'hFFFF;
            e.rd = !is_wr && (t == 2 || t == 3);
            e.wr = is_wr && (t == 2 || t == 3);
            e.wd = wd; e.pc = p; e.sp = s; e.tag = tag;
            q.push_back(e);
        end
    endtask

    // behavioural model of one instruction starting at m_pc
    task automatic plan_instr();
        int p = m_pc;
        int s = m_sp;
        int op = peek_r(p);
        int lo, hi, ra;
        if (op == 8'hCD) begin
            add_mc(1, 6, p, 0, 0, p, s, 3);                    // R3: long fetch
            p = (p + 1) & 16'hFFFF;
            lo = peek_r(p); add_mc(2, 3, p, 0, 0, p, s, 4);   // R4: low target
            p = (p + 1) & 16'hFFFF;
            hi = peek_r(p); add_mc(2, 3, p, 0, 0, p, s, 4);   // R4: high target
            p = (p + 1) & 16'hFFFF;
            ra = p;
            // R5 R6: push high then low, pc holds return address; R10 on wrap
            add_mc(3, 3, s - 1, 1, ra >> 8, p, s, (s == 0) ? 10 : 5);
            rmem[(s - 1) & 16'hFFFF] = 8'(ra >> 8);
            s = (s - 1) & 16'hFFFF;
            add_mc(3, 3, s - 1, 1, ra & 8'hFF, p, s, (s == 0) ? 10 : 6);
            rmem[(s - 1) & 16'hFFFF] = 8'(ra);
            s = (s - 1) & 16'hFFFF;
            p = (hi << 8) | lo;
        end else if (op == 8'hC9) begin
            add_mc(1, 4, p, 0, 0, p, s, 2);                    // R2 fetch
            p = (p + 1) & 16'hFFFF;
            lo = peek_r(s); add_mc(2, 3, s, 0, 0, p, s, 7);   // R7 pop low
            s = (s + 1) & 16'hFFFF;
            hi = peek_r(s); add_mc(2, 3, s, 0, 0, p, s, 7);   // R7 pop high
            s = (s + 1) & 16'hFFFF;
            p = (hi << 8) | lo;
        end else begin
            add_mc(1, 4, p, 0, 0, p, s, 8);                    // R8 no-op
            p = (p + 1) & 16'hFFFF;
        end
        m_pc = p;
        m_sp = s;
    endtask

    task automatic load(int a, logic [7:0] v);
        dmem[a] = v;
        rmem[a] = v;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : stim
        // program: nested calls, a no-op, returns, stack wrap through zero
        load(16'h0000, 8'hCD); load(16'h0001, 8'h00); load(16'h0002, 8'h01);
        load(16'h0003, 8'hC9);
        load(16'h0100, 8'h00); load(16'h0101, 8'hCD); load(16'h0102, 8'h00);
        load(16'h0103, 8'h02); load(16'h0104, 8'hC9);
        load(16'h0200, 8'h3E); load(16'h0201, 8'hC9);
        load(16'h00CD, 8'hCD); load(16'h00CE, 8'hFF); load(16'h00CF, 8'hFF);

        repeat (3) @(negedge clk);
        // R1: reset state
        chk(pc == 16'h0, 1, "pc in reset", int'(pc), 0);
        chk(sp == 16'h0, 1, "sp in reset", int'(sp), 0);
        chk(tstate == 3'd1, 1, "tstate in reset", int'(tstate), 1);
        chk(mcycle == 2'b01, 1, "mcycle in reset", int'(mcycle), 1);
        chk(!mem_rd && !mem_wr, 1, "strobes in reset", int'({mem_rd, mem_wr}), 0);
        rst_n = 1'b1;

        for (int cyc = 0; cyc < 260; cyc++) begin
            exp_t e;
            if (q.size() == 0) plan_instr();
            e = q.pop_front();
            mem_rdata = peek_d(int'(mem_addr));
            chk(int'(mcycle) == e.mc, e.tag, "mcycle", int'(mcycle), e.mc);
            chk(int'(tstate) == e.ts, e.tag, "tstate", int'(tstate), e.ts);
            chk(int'(mem_addr) == e.addr, e.tag, "mem_addr", int'(mem_addr), e.addr);
            // R9: strobe timing and exclusivity
            chk(mem_rd == e.rd && mem_wr == e.wr, 9, "strobes",
                int'({mem_rd, mem_wr}), int'({e.rd, e.wr}));
            if (e.wr) chk(int'(mem_wdata) == e.wd, e.tag, "mem_wdata", int'(mem_wdata), e.wd);
            chk(int'(pc) == e.pc, e.tag, "pc", int'(pc), e.pc);
            chk(int'(sp) == e.sp, e.tag, "sp", int'(sp), e.sp);
            @(negedge clk);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule